// File: doc/BRIEF.md
# Word FIFO with Hysteretic Fill Request

This block is a word-wide FIFO that sits between a DMA engine and a byte-oriented peripheral. It tracks how many bytes it holds and drives a data-request line back to the DMA engine. The request rises when the contents fall to a programmable low mark, given in bytes. It stays raised while the DMA refills the buffer and drops only when free space has shrunk to a high mark. The high mark is set by a small granularity code that counts free space in 4-byte words.

Because the two thresholds differ, the request line does not toggle on every transferred word. The DMA engine gets long bursts of work and then a long pause. Pushes into a full buffer and pops from an empty one are dropped and leave sticky error flags. A frame-end hint input exists, but framing is not supported, so that input has no effect.

Top module: `fifo_wm_dreq`

## Requirements
- R1: After reset the FIFO is empty: `empty`=1, `full`=0, `fill_bytes`=0. Both `overflow` and `underflow` are cleared, and `dreq`=1.
- R2: Words leave in the order they entered. The FIFO holds 128 words (512 bytes). The word removed by an accepted pop appears on `pop_data` right after the clock edge that accepts the pop.
- R3: `fill_bytes` is 4 times the number of stored words and changes at the edge that accepts a push or pop. A push and a pop accepted at the same edge leave it unchanged.
- R4: If `fill_bytes` <= `low_mark` (9-bit byte count) at an edge, `dreq` is 1 after the next edge.
- R5: If `fill_bytes` > `low_mark` and free space (512 - `fill_bytes`) > 4 x `gran_code`, then `dreq` keeps its value at the next edge.
- R6: If `fill_bytes` > `low_mark` and free space <= 4 x `gran_code`, then `dreq` is 0 after the next edge. Code 0 clears only when the FIFO is full. Code 1 clears at 508 bytes.
- R7: A push while full is dropped: contents and `fill_bytes` are unchanged. `overflow` becomes 1 and stays 1 until reset.
- R8: A pop while empty is dropped: `fill_bytes` stays 0. `underflow` becomes 1 and stays 1 until reset.
- R9: `eof_hint` has no effect on data, fill level or `dreq`.
- R10: A change of `low_mark` or `gran_code` is used at the next edge. If the level is at or below a new low mark, `dreq` rises one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Write one word |
| push_data | input | 32 | Word to write |
| pop_en | input | 1 | Read one word |
| pop_data | output | 32 | Last word read |
| low_mark | input | 9 | Request-raise threshold in bytes |
| gran_code | input | 3 | Request-release free space in 4-byte units |
| eof_hint | input | 1 | Frame-end hint, unsupported; hold low |
| fill_bytes | output | 10 | Bytes stored |
| full | output | 1 | No free word |
| empty | output | 1 | No stored word |
| overflow | output | 1 | Sticky: push while full seen |
| underflow | output | 1 | Sticky: pop while empty seen |
| dreq | output | 1 | Data request to the DMA engine |

## Verification
The assertions check the request decision on every cycle. From the registered level and the two threshold inputs they check whether `dreq` must be set, must be cleared or must hold. They also check that the error flags stay set once raised, that dropped pushes and pops leave the word count unchanged, and that the count stays within bounds.

Only the directed scenarios can show the rest. One is data order across a full fill and drain. Another is the exact level at which each granularity code releases the request. A third is the hysteresis band seen from both sides: the request stays low while the level drains toward the low mark, and stays high while it refills past it. The scenarios also cover the response to a threshold change and the absence of any effect from the frame-end hint.

// File: rtl/wmq_pkg.sv
package wmq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } req_act_t;
endpackage

// File: rtl/wmq_storage.sv
module wmq_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/wmq_level.sv
module wmq_level #(
  parameter int DEPTH = 128,
  parameter int BPW   = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FILL_W = $clog2(DEPTH * BPW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [FILL_W-1:0] fill_bytes,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);
  localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] PTR_END = ADDR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count_q;

  assign full    = (count_q == CNT_MAX);
  assign empty   = (count_q == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign fill_bytes = FILL_W'(count_q) * FILL_W'(BPW);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push_req && full)  overflow  <= 1'b1;
      if (pop_req  && empty) underflow <= 1'b1;
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_MAX);
  a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r7_drop_push: assert property (@(posedge clk) disable iff (rst)
    (push_req && full && !pop_req) |=> $stable(count_q));
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r8_drop_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push_req) |=> (count_q == '0));
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
endmodule

// File: rtl/wmq_alarm.sv
module wmq_alarm
  import wmq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int BPW    = 4,
  parameter int LOW_W  = 9,
  parameter int GRAN_W = 3,
  localparam int FILL_W = $clog2(DEPTH * BPW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILL_W-1:0] fill_bytes,
  input  logic [LOW_W-1:0]  low_mark,
  input  logic [GRAN_W-1:0] gran_code,
  output logic              dreq
);
  localparam logic [FILL_W-1:0] CAP = FILL_W'(DEPTH * BPW);

  logic [FILL_W-1:0] free_bytes;
  logic [FILL_W-1:0] high_free;
  req_act_t          act;

  assign free_bytes = CAP - fill_bytes;
  assign high_free  = FILL_W'(gran_code) * FILL_W'(BPW);

  always_comb begin
    if (fill_bytes <= FILL_W'(low_mark))  act = ACT_SET;
    else if (free_bytes <= high_free)     act = ACT_CLEAR;
    else                                  act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) dreq <= 1'b1;
    else begin
      case (act)
        ACT_SET:   dreq <= 1'b1;
        ACT_CLEAR: dreq <= 1'b0;
        default:   dreq <= dreq;
      endcase
    end
  end

  a_r4_set_at_low: assert property (@(posedge clk) disable iff (rst)
    (fill_bytes <= FILL_W'(low_mark)) |=> dreq);
  a_r6_clear_at_high: assert property (@(posedge clk) disable iff (rst)
    ((fill_bytes > FILL_W'(low_mark)) &&
     ((CAP - fill_bytes) <= FILL_W'(gran_code) * FILL_W'(BPW))) |=> !dreq);
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    ((fill_bytes > FILL_W'(low_mark)) &&
     ((CAP - fill_bytes) > FILL_W'(gran_code) * FILL_W'(BPW))) |=> $stable(dreq));
endmodule

// File: rtl/fifo_wm_dreq.sv
module fifo_wm_dreq #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int BPW    = 4,
  parameter int LOW_W  = 9,
  parameter int GRAN_W = 3,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH * BPW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  output logic [DATA_W-1:0] pop_data,
  input  logic [LOW_W-1:0]  low_mark,
  input  logic [GRAN_W-1:0] gran_code,
  input  logic              eof_hint,
  output logic [FILL_W-1:0] fill_bytes,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic              dreq
);
  logic              push_ok, pop_ok;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic              unused_eof;

  // framing is unsupported (R9): the hint is deliberately left unconnected
  assign unused_eof = eof_hint;

  wmq_level #(.DEPTH(DEPTH), .BPW(BPW)) u_level (
    .clk(clk), .rst(rst),
    .push_req(push_en), .pop_req(pop_en),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .fill_bytes(fill_bytes), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  wmq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk),
    .wr_en(push_ok), .wr_addr(wr_ptr), .wr_data(push_data),
    .rd_en(pop_ok), .rd_addr(rd_ptr), .rd_data(pop_data)
  );

  wmq_alarm #(.DEPTH(DEPTH), .BPW(BPW), .LOW_W(LOW_W), .GRAN_W(GRAN_W)) u_alarm (
    .clk(clk), .rst(rst),
    .fill_bytes(fill_bytes), .low_mark(low_mark), .gran_code(gran_code),
    .dreq(dreq)
  );
endmodule

// File: tb/tb_fifo_wm_dreq.sv
module tb_fifo_wm_dreq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_en = 1'b0;
  logic [31:0] push_data = '0;
  logic        pop_en = 1'b0;
  logic [31:0] pop_data;
  logic [8:0]  low_mark = 9'd32;
  logic [2:0]  gran_code = 3'd0;
  logic        eof_hint = 1'b0;
  logic [9:0]  fill_bytes;
  logic        full, empty, overflow, underflow, dreq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_wm_dreq dut (
    .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
    .pop_en(pop_en), .pop_data(pop_data), .low_mark(low_mark),
    .gran_code(gran_code), .eof_hint(eof_hint), .fill_bytes(fill_bytes),
    .full(full), .empty(empty), .overflow(overflow), .underflow(underflow),
    .dreq(dreq)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0000 + 32'(i * 7);
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] d, input logic re);
    @(negedge clk);
    push_en = we; push_data = d; pop_en = re;
    @(posedge clk);
    #1;
    push_en = 1'b0; pop_en = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1", "empty", empty, 1);
    check("R1", "full", full, 0);
    check("R1", "fill", fill_bytes, 0);
    check("R1", "overflow", overflow, 0);
    check("R1", "underflow", underflow, 0);
    check("R1", "dreq", dreq, 1);
  endtask

  task automatic t_fill_drain_gran0();
    low_mark = 9'd32; gran_code = 3'd0;
    do_reset();
    for (int i = 0; i < 127; i++) step(1'b1, pat(i), 1'b0);
    idle();
    check("R3", "fill at 127 words", fill_bytes, 508);
    check("R5", "dreq held high below full", dreq, 1);
    step(1'b1, pat(127), 1'b0);
    idle();
    check("R6", "dreq cleared at full, code 0", dreq, 0);
    check("R2", "full at 128 words", full, 1);
    step(1'b1, 32'hDEAD_BEEF, 1'b0);
    idle();
    check("R7", "fill after dropped push", fill_bytes, 512);
    check("R7", "overflow set", overflow, 1);
    for (int i = 0; i < 119; i++) begin
      step(1'b0, '0, 1'b1);
      check("R2", $sformatf("order word %0d", i), pop_data, pat(i));
    end
    idle();
    check("R3", "fill after drain to 36", fill_bytes, 36);
    check("R5", "dreq held low above low mark", dreq, 0);
    step(1'b0, '0, 1'b1);
    idle();
    check("R4", "dreq set at 32 bytes", dreq, 1);
    step(1'b1, 32'h0BAD_F00D, 1'b0);
    idle();
    check("R5", "dreq held high after refill past low", dreq, 1);
    for (int i = 120; i < 128; i++) begin
      step(1'b0, '0, 1'b1);
      check("R7", $sformatf("word %0d intact after dropped push", i), pop_data, pat(i));
    end
    step(1'b0, '0, 1'b1);
    check("R2", "late word order", pop_data, 32'h0BAD_F00D);
    check("R2", "empty after drain", empty, 1);
    step(1'b0, '0, 1'b1);
    idle();
    check("R8", "fill after dropped pop", fill_bytes, 0);
    check("R8", "underflow set", underflow, 1);
    check("R8", "pop_data unchanged on dropped pop", pop_data, 32'h0BAD_F00D);
    check("R7", "overflow still set", overflow, 1);
  endtask

  task automatic t_gran1_and_mark_change();
    low_mark = 9'd32; gran_code = 3'd1;
    do_reset();
    for (int i = 0; i < 126; i++) step(1'b1, pat(i), 1'b0);
    idle();
    check("R5", "dreq high at 504, code 1", dreq, 1);
    step(1'b1, pat(126), 1'b0);
    idle();
    check("R6", "dreq cleared at 508, code 1", dreq, 0);
    step(1'b1, pat(127), 1'b1);
    check("R3", "fill after push+pop", fill_bytes, 508);
    check("R3", "pop data during push+pop", pop_data, pat(0));
    low_mark = 9'd508;
    idle();
    check("R10", "dreq set after low mark raised", dreq, 1);
    low_mark = 9'd100;
    idle();
    check("R10", "dreq cleared after low mark lowered", dreq, 0);
    gran_code = 3'd0;
    idle();
    check("R10", "dreq holds after code 0 at 508", dreq, 0);
  endtask

  task automatic t_eof_ignored();
    low_mark = 9'd8; gran_code = 3'd0;
    do_reset();
    eof_hint = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, pat(40 + i), 1'b0);
    idle();
    check("R9", "fill with hint high", fill_bytes, 12);
    check("R9", "dreq with hint high", dreq, 1);
    step(1'b0, '0, 1'b1);
    check("R9", "data with hint high", pop_data, pat(40));
    eof_hint = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_fill_drain_gran0();
    t_gran1_and_mark_change();
    t_reset_state();
    t_eof_ignored();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule